// File: doc/BRIEF.md
# External DMA transfer sequencer

A single-channel engine that copies data between two external address ranges over a shared bus. Each transfer is a read from the source address followed by a write of the same data to the destination address. Both addresses then advance by one and the transfer counter drops by one. The pair cannot be split: once the read is acknowledged, the write follows on the next cycle with the bus still held.

The engine raises a bus request and starts only after it sees the grant. It drops the request only at fixed points, so that a refresh, an external bus release or a lower-priority internal master can take the bus. Those points are:

- after every transfer in cycle-steal mode;
- at the end of the whole transfer in burst mode;
- at the end of each block in block mode;
- after every transfer when the give-up option is set;
- after the current write when the yield input reports a waiting refresh or release request.

Software loads the configuration while the engine is idle, then sets enable. A clear-enable pulse aborts the run at the next transfer boundary. The address, count and block registers stay as they are, so a later set-enable pulse resumes where the run stopped. A block error flag records an abort that fell partway through a block.

Top module: `xdma_seq`

## Requirements
- R1: After a read is acknowledged, the next cycle carries the write of that data to the destination address with `busReq` still high. The bus is never released between a read and its write.
- R2: `busRd` and `busWr` are asserted only while `busReq` and `busGnt` are both high. From a request, the first read begins only after `busGnt` is seen.
- R3: With `cfgMode` = 0 (cycle steal), `busReq` goes low in the cycle after every acknowledged write. Encoding 3 behaves the same way.
- R4: With `cfgMode` = 1 (burst), the bus is kept across transfers and is released once, when the count reaches zero. The exception is `yieldReq` high at a write acknowledge, which releases the bus after that write.
- R5: With `cfgMode` = 2 (block), the bus is released after the last write of each block of `cfgBlkSize` transfers. `blkCount` reloads to `cfgBlkSize` at each block boundary.
- R6: With `cfgGiveUp` = 1 in burst or block mode, the bus is released after every write.
- R7: Each acknowledged write advances `srcAddr` and `dstAddr` by one and lowers `xferCount` by one. When `xferCount` reaches zero, `enable` clears and `done` is set.
- R8: A `enaClr` pulse stops the engine right after the write of the transfer in progress, with all registers retained. In block mode `blkErr` is set only when the stop falls inside a block, not at a block boundary.
- R9: A later `enaSet` resumes from the retained addresses and counts, finishing a partly done block before a full one. `blkErr` stays set until the next `cfgLoad`.
- R10: `enaSet` while `xferCount` is zero has no effect: `enable` and `busReq` stay low and `done` keeps its value.
- R11: After reset, `enable`, `done`, `blkErr`, `busReq`, `busRd` and `busWr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Load configuration fields (accepted only while idle) |
| cfgMode | input | 2 | 0 cycle steal, 1 burst, 2 block, 3 as cycle steal |
| cfgGiveUp | input | 1 | Release the bus after every transfer in burst/block mode |
| cfgSrc | input | ADDR_W | Source start address |
| cfgDst | input | ADDR_W | Destination start address |
| cfgCount | input | CNT_W | Number of transfers |
| cfgBlkSize | input | BLK_W | Transfers per block (nonzero) |
| enaSet | input | 1 | Pulse: start or resume |
| enaClr | input | 1 | Pulse: abort at next transfer boundary |
| enable | output | 1 | Engine running |
| done | output | 1 | Count reached zero |
| blkErr | output | 1 | Aborted partway through a block |
| srcAddr | output | ADDR_W | Next source address |
| dstAddr | output | ADDR_W | Next destination address |
| xferCount | output | CNT_W | Transfers remaining |
| blkCount | output | BLK_W | Transfers remaining in current block |
| busReq | output | 1 | External bus request |
| busGnt | input | 1 | External bus grant |
| yieldReq | input | 1 | Refresh or bus-release request waiting |
| busAddr | output | ADDR_W | Bus address |
| busRd | output | 1 | Read cycle |
| busWr | output | 1 | Write cycle |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data |
| busAck | input | 1 | Cycle acknowledge |

## Verification
The assertions check three things on every cycle: that a read acknowledge is always followed by the matching write with the request held, that no bus cycle runs without request and grant, and that cycle-steal mode drops the request after each write. They also check that `done` and `blkErr` only rise with `enable` low, and `blkErr` only in block mode. How many releases each mode produces, the mid-block versus boundary abort distinction, and the resume path all depend on whole scenarios. These are shown by the bench, which counts releases and compares the copied memory and the retained registers against its own model.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

  typedef enum logic [1:0] {
    MODE_STEAL = 2'd0,
    MODE_BURST = 2'd1,
    MODE_BLOCK = 2'd2,
    MODE_RSVD  = 2'd3
  } xferMode_e;

  // strobes from the sequencer to the register file
  typedef struct packed {
    logic load;   // capture configuration
    logic latch;  // capture read data
    logic step;   // transfer completed: advance addresses and counters
  } dpStrobe_t;

endpackage

// File: rtl/xdma_path.sv
module xdma_path
  import xdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        cfgMode,
  input  logic              cfgGiveUp,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [BLK_W-1:0]  cfgBlkSize,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [BLK_W-1:0]  blkCount,
  output logic [1:0]        modeCur,
  output logic              giveUpCur,
  output logic [DATA_W-1:0] holdData,
  output logic              countZero,
  output logic              countLast,
  output logic              blkLast,
  output logic              blkFull
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [BLK_W-1:0]  BLK_ONE  = BLK_W'(1);

  logic [BLK_W-1:0] blkSizeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr    <= '0;
      dstAddr    <= '0;
      xferCount  <= '0;
      blkCount   <= '0;
      blkSizeReg <= '0;
      modeCur    <= MODE_STEAL;
      giveUpCur  <= 1'b0;
    end else if (strobe.load) begin
      srcAddr    <= cfgSrc;
      dstAddr    <= cfgDst;
      xferCount  <= cfgCount;
      blkCount   <= cfgBlkSize;
      blkSizeReg <= cfgBlkSize;
      modeCur    <= cfgMode;
      giveUpCur  <= cfgGiveUp;
    end else if (strobe.step) begin
      srcAddr   <= srcAddr + ADDR_ONE;
      dstAddr   <= dstAddr + ADDR_ONE;
      xferCount <= xferCount - CNT_ONE;
      blkCount  <= blkLast ? blkSizeReg : blkCount - BLK_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
    end else if (strobe.latch) begin
      holdData <= busRdata;
    end
  end

  assign countZero = (xferCount == '0);
  assign countLast = (xferCount == CNT_ONE);
  assign blkLast   = (blkCount == BLK_ONE);
  assign blkFull   = (blkCount == blkSizeReg);

endmodule

// File: rtl/xdma_ctrl.sv
module xdma_ctrl
  import xdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgLoad,
  input  logic       enaSet,
  input  logic       enaClr,
  input  logic       busGnt,
  input  logic       busAck,
  input  logic       yieldReq,
  input  logic [1:0] modeCur,
  input  logic       giveUpCur,
  input  logic       countZero,
  input  logic       countLast,
  input  logic       blkLast,
  input  logic       blkFull,
  output dpStrobe_t  strobe,
  output logic       busReq,
  output logic       busRd,
  output logic       busWr,
  output logic       enable,
  output logic       done,
  output logic       blkErr
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_REL
  } seqState_e;

  seqState_e state;
  logic abortPend;
  logic isBlock;
  logic holdBus;
  logic releaseNow;
  logic stopReq;

  always_comb begin
    isBlock    = (modeCur == MODE_BLOCK);
    holdBus    = (modeCur == MODE_BURST) || isBlock;
    releaseNow = !holdBus || giveUpCur || yieldReq || (isBlock && blkLast);
    stopReq    = abortPend || enaClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      enable    <= 1'b0;
      done      <= 1'b0;
      blkErr    <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cfgLoad) begin
            done   <= 1'b0;
            blkErr <= 1'b0;
          end else if (enaSet && !countZero) begin
            enable    <= 1'b1;
            done      <= 1'b0;
            abortPend <= 1'b0;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (stopReq) begin
            state     <= ST_IDLE;
            enable    <= 1'b0;
            abortPend <= 1'b0;
            if (isBlock && !blkFull) blkErr <= 1'b1;
          end else if (busGnt) begin
            state <= ST_RD;
          end
        end
        ST_RD: begin
          if (enaClr) abortPend <= 1'b1;
          if (busAck) state <= ST_WR;
        end
        ST_WR: begin
          if (busAck) begin
            if (countLast) begin
              state     <= ST_IDLE;
              enable    <= 1'b0;
              done      <= 1'b1;
              abortPend <= 1'b0;
            end else if (stopReq) begin
              state     <= ST_IDLE;
              enable    <= 1'b0;
              abortPend <= 1'b0;
              if (isBlock && !blkLast) blkErr <= 1'b1;
            end else if (releaseNow) begin
              state <= ST_REL;
            end else begin
              state <= ST_RD;
            end
          end else if (enaClr) begin
            abortPend <= 1'b1;
          end
        end
        ST_REL: begin
          if (stopReq) begin
            state     <= ST_IDLE;
            enable    <= 1'b0;
            abortPend <= 1'b0;
            if (isBlock && !blkFull) blkErr <= 1'b1;
          end else begin
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busReq       = (state == ST_REQ) || (state == ST_RD) || (state == ST_WR);
    busRd        = (state == ST_RD);
    busWr        = (state == ST_WR);
    strobe.load  = (state == ST_IDLE) && cfgLoad;
    strobe.latch = (state == ST_RD) && busAck;
    strobe.step  = (state == ST_WR) && busAck;
  end

endmodule

// File: rtl/xdma_seq.sv
module xdma_seq
  import xdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgMode,
  input  logic              cfgGiveUp,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [BLK_W-1:0]  cfgBlkSize,
  input  logic              enaSet,
  input  logic              enaClr,
  output logic              enable,
  output logic              done,
  output logic              blkErr,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  xferCount,
  output logic [BLK_W-1:0]  blkCount,
  output logic              busReq,
  input  logic              busGnt,
  input  logic              yieldReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck
);

  dpStrobe_t         strobe;
  logic [1:0]        modeCur;
  logic              giveUpCur;
  logic [DATA_W-1:0] holdData;
  logic              countZero;
  logic              countLast;
  logic              blkLast;
  logic              blkFull;

  xdma_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .enaSet    (enaSet),
    .enaClr    (enaClr),
    .busGnt    (busGnt),
    .busAck    (busAck),
    .yieldReq  (yieldReq),
    .modeCur   (modeCur),
    .giveUpCur (giveUpCur),
    .countZero (countZero),
    .countLast (countLast),
    .blkLast   (blkLast),
    .blkFull   (blkFull),
    .strobe    (strobe),
    .busReq    (busReq),
    .busRd     (busRd),
    .busWr     (busWr),
    .enable    (enable),
    .done      (done),
    .blkErr    (blkErr)
  );

  xdma_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .BLK_W  (BLK_W)
  ) pathI (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgMode    (cfgMode),
    .cfgGiveUp  (cfgGiveUp),
    .cfgSrc     (cfgSrc),
    .cfgDst     (cfgDst),
    .cfgCount   (cfgCount),
    .cfgBlkSize (cfgBlkSize),
    .busRdata   (busRdata),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr),
    .xferCount  (xferCount),
    .blkCount   (blkCount),
    .modeCur    (modeCur),
    .giveUpCur  (giveUpCur),
    .holdData   (holdData),
    .countZero  (countZero),
    .countLast  (countLast),
    .blkLast    (blkLast),
    .blkFull    (blkFull)
  );

  assign busAddr  = busWr ? dstAddr : srcAddr;
  assign busWdata = holdData;

endmodule

// File: rtl/xdma_seq_chk.sv
module xdma_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busRd,
  input logic       busWr,
  input logic       busAck,
  input logic       busReq,
  input logic       busGnt,
  input logic       enable,
  input logic       done,
  input logic       blkErr,
  input logic [1:0] modeCur
);

  // R1
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAck) |=> (busWr && busReq));

  // R2
  op_owns_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> (busReq && busGnt));

  // R3
  steal_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAck && ((modeCur == 2'd0) || (modeCur == 2'd3))) |=> !busReq);

  // R7
  done_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !enable);

  // R8
  blkerr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blkErr) |-> ((modeCur == 2'd2) && !enable));

endmodule

bind xdma_seq xdma_seq_chk chkI (
  .clk     (clk),
  .rstN    (rstN),
  .busRd   (busRd),
  .busWr   (busWr),
  .busAck  (busAck),
  .busReq  (busReq),
  .busGnt  (busGnt),
  .enable  (enable),
  .done    (done),
  .blkErr  (blkErr),
  .modeCur (modeCur)
);

// File: tb/xdma_seq_tb_top.sv
module xdma_seq_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int BLK_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [1:0] cfgMode = 2'd0;
  logic cfgGiveUp = 1'b0;
  logic [ADDR_W-1:0] cfgSrc = '0;
  logic [ADDR_W-1:0] cfgDst = '0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic [BLK_W-1:0] cfgBlkSize = '0;
  logic enaSet = 1'b0;
  logic enaClrTask = 1'b0;
  logic abortPulse = 1'b0;
  logic enaClr;
  logic enable, done, blkErr;
  logic [ADDR_W-1:0] srcAddr, dstAddr, busAddr;
  logic [CNT_W-1:0] xferCount;
  logic [BLK_W-1:0] blkCount;
  logic busReq, busRd, busWr;
  logic busGnt = 1'b0;
  logic yieldReq = 1'b0;
  logic busAck = 1'b0;
  logic [DATA_W-1:0] busWdata;
  logic [DATA_W-1:0] busRdata = '0;

  assign enaClr = enaClrTask | abortPulse;

  always #4 clk = ~clk;

  xdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BLK_W(BLK_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode), .cfgGiveUp(cfgGiveUp),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgCount(cfgCount), .cfgBlkSize(cfgBlkSize),
    .enaSet(enaSet), .enaClr(enaClr), .enable(enable), .done(done), .blkErr(blkErr),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .xferCount(xferCount), .blkCount(blkCount),
    .busReq(busReq), .busGnt(busGnt), .yieldReq(yieldReq), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  // reference state
  logic [7:0] mem [0:1023];
  int checks = 0;
  int fails = 0;
  int expSrc = 0;
  int expDst = 0;
  int wrNum = 0;
  int relCount = 0;
  int abortAt = 0;
  int latency = 0;
  int waitLeft = 0;
  int cycles = 0;
  bit prevRdAcc = 1'b0;
  bit prevReq = 1'b0;
  logic [7:0] rdVal = '0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle compare and bus/arbiter model
  always @(negedge clk) begin
    abortPulse = 1'b0;
    if (rstN) begin
      if (prevRdAcc) begin
        check("R1", "write with bus held after read", {busWr, busReq}, 2'b11);
        check("R1", "write address", busAddr, expDst);
        check("R1", "write data", busWdata, rdVal);
      end
      if (busRd || busWr) check("R2", "grant during bus cycle", busGnt, 1);
      if (prevReq && !busReq) relCount++;
    end
    prevReq = busReq;
    busGnt = busReq;
    if (busRd || busWr) begin
      if (waitLeft > 0) begin
        waitLeft--;
        busAck = 1'b0;
      end else begin
        busAck = 1'b1;
        waitLeft = latency;
      end
    end else begin
      busAck = 1'b0;
      waitLeft = latency;
    end
    busRdata = mem[busAddr[9:0]];
    prevRdAcc = 1'b0;
    if (busRd && busAck) begin
      check("R7", "read address", busAddr, expSrc);
      rdVal = mem[busAddr[9:0]];
      prevRdAcc = 1'b1;
    end
    if (busWr && busAck) begin
      mem[busAddr[9:0]] = busWdata;
      wrNum++;
      expSrc++;
      expDst++;
      if (wrNum == abortAt) abortPulse = 1'b1;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic loadCfg(input int mode, input bit gu, input int src, input int dst, input int n, input int blk);
    for (int i = 0; i < n; i++) mem[src + i] = pat(src + i);
    for (int i = 0; i < n; i++) mem[dst + i] = 8'hEE;
    @(negedge clk);
    cfgMode = 2'(mode); cfgGiveUp = gu; cfgSrc = ADDR_W'(src); cfgDst = ADDR_W'(dst);
    cfgCount = CNT_W'(n); cfgBlkSize = BLK_W'(blk); cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    expSrc = src; expDst = dst; wrNum = 0; relCount = 0;
  endtask

  task automatic pulseSet();
    @(negedge clk); enaSet = 1'b1;
    @(negedge clk); enaSet = 1'b0;
  endtask

  task automatic waitIdle();
    while (enable) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkCopy(input string req, input int src, input int dst, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[dst + i] != pat(src + i)) bad++;
    check(req, "copied bytes mismatching", bad, 0);
  endtask

  task automatic runCase(input string req, input int mode, input bit gu, input bit yl, input int src,
                         input int dst, input int n, input int blk, input int lat, input int expRel);
    latency = lat; yieldReq = yl; abortAt = 0;
    loadCfg(mode, gu, src, dst, n, blk);
    pulseSet();
    waitIdle();
    yieldReq = 1'b0;
    check(req, "done", done, 1);
    check("R7", "enable cleared", enable, 0);
    check("R7", "count", xferCount, 0);
    check("R7", "src end", srcAddr, src + n);
    check("R7", "dst end", dstAddr, dst + n);
    check(req, "bus releases", relCount, expRel);
    checkCopy(req, src, dst, n);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset outputs", {enable, done, blkErr, busReq, busRd, busWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "idle after reset", {enable, busReq}, 0);

    runCase("R3", 0, 1'b0, 1'b0, 16, 512, 4, 2, 0, 4);
    runCase("R3", 3, 1'b0, 1'b0, 40, 560, 3, 2, 1, 3);
    runCase("R4", 1, 1'b0, 1'b0, 64, 600, 5, 2, 1, 1);
    runCase("R4", 1, 1'b0, 1'b1, 80, 640, 4, 2, 0, 4);
    runCase("R5", 2, 1'b0, 1'b0, 96, 680, 6, 3, 2, 2);
    check("R5", "block counter reloaded", blkCount, 3);
    runCase("R6", 1, 1'b1, 1'b0, 120, 720, 5, 4, 0, 5);
    runCase("R6", 2, 1'b1, 1'b0, 140, 760, 6, 3, 1, 6);

    // R10 start with zero count ignored
    pulseSet();
    repeat (3) @(negedge clk);
    check("R10", "enable/busReq stay low", {enable, busReq}, 0);
    check("R10", "done kept", done, 1);

    // R8/R9 abort mid-block and resume
    latency = 1;
    loadCfg(2, 1'b0, 160, 800, 8, 4);
    abortAt = 3;
    pulseSet();
    waitIdle();
    abortAt = 0;
    check("R8", "enable cleared on abort", enable, 0);
    check("R8", "not done", done, 0);
    check("R8", "block error mid-block", blkErr, 1);
    check("R8", "count retained", xferCount, 5);
    check("R8", "src retained", srcAddr, 163);
    check("R8", "block count retained", blkCount, 1);
    relCount = 0;
    pulseSet();
    waitIdle();
    check("R9", "done after resume", done, 1);
    check("R9", "block error kept", blkErr, 1);
    check("R9", "releases after resume", relCount, 2);
    checkCopy("R9", 160, 800, 8);

    // R8 abort at block boundary: no error
    latency = 0;
    loadCfg(2, 1'b0, 200, 840, 8, 4);
    check("R9", "load clears block error", blkErr, 0);
    abortAt = 4;
    pulseSet();
    waitIdle();
    abortAt = 0;
    check("R8", "no block error at boundary", blkErr, 0);
    check("R8", "count at boundary", xferCount, 4);
    check("R8", "block count reloaded", blkCount, 4);
    relCount = 0;
    pulseSet();
    waitIdle();
    check("R9", "done after boundary resume", done, 1);
    check("R9", "releases after boundary resume", relCount, 1);
    checkCopy("R9", 200, 840, 8);

    // R8 abort in burst mode
    latency = 2;
    loadCfg(1, 1'b0, 240, 880, 5, 2);
    abortAt = 2;
    pulseSet();
    waitIdle();
    abortAt = 0;
    check("R8", "burst abort no block error", blkErr, 0);
    check("R8", "burst count retained", xferCount, 3);
    check("R8", "burst dst retained", dstAddr, 882);
    pulseSet();
    waitIdle();
    check("R9", "burst resume done", done, 1);
    checkCopy("R9", 240, 880, 5);

    finishRun();
  end

endmodule